// File: doc/BRIEF.md
# Clock-Fail Fault NMI Controller with Escalation Watchdog

This block gathers fault conditions for a small processor system. Its main input is a clock-failure level. It also takes generic fault levels, such as RAM and flash ECC errors. Each fault sets its own sticky flag. A set flag sends a single-cycle non-maskable interrupt request to the CPU and records that request in an interrupt-status bit. The clock-failure flag also drives a protection trip output to the PWM shutdown logic. The trip stays asserted until software clears that flag, so the PWM stages stay safe until software decides the system may resume.

Every flag is sticky. A write-one clear is refused for any bit whose cause is still present, so a lasting fault sets the flag again without a gap. While any flag stays set, an escalation counter runs. If software leaves the flags set until the counter reaches the programmed period, the block sends a one-cycle system-reset pulse. Clearing the interrupt-status bit does not stop the counter. It only allows the next interrupt request. A force strobe lets test software set flags with the same effects as a real fault.

Top module: `fault_nmi_ctrl`

## Requirements
- R1: After reset, all flags, the interrupt-status bit, the request, the trip, the reset pulse and the counter are 0. The period reads the parameter default of 512.
- R2: A high fault level `fault_i[k]` seen at a clock edge makes `flag_o[k]` read 1 after that edge. Bit 0 is clock failure, bit 1 is RAM ECC, bit 2 is flash ECC and bit 3 is a spare source.
- R3: `trip_o` equals `flag_o[0]`. It falls only after a clear of bit 0 has been accepted.
- R4: When `flag_clr_i` is high, each bit set in `reg_mask_i` is cleared. A bit whose fault level or force is active in the same cycle stays set instead.
- R5: When `flag_force_i` is high, the flags in `reg_mask_i` are set, with the same interrupt, trip and counter effects as a real fault.
- R6: When any flag is set and the interrupt-status bit is 0, `nmi_req_o` goes high for exactly one cycle on the next edge. `nmiint_o` goes to 1 on the same edge.
- R7: `nmiint_o` stays 1 until `nmiint_clr_i` is high at an edge. If flags are still set after that, a new request follows one cycle later.
- R8: The counter adds 1 per cycle while any flag is set. It is 0 one edge after no flag is set. `nmiint_clr_i` has no effect on it.
- R9: When the counter is at or above the period while a flag is set, `wd_reset_o` pulses for one cycle. The counter then holds until all flags clear.
- R10: A write with `wd_period_we_i` high makes `wd_period_o` show the new value after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_i | input | 4 | Fault condition levels, bit 0 is clock failure |
| reg_mask_i | input | 4 | Bit mask for the clear and force strobes |
| flag_clr_i | input | 1 | Write-one clear strobe for flags |
| flag_force_i | input | 1 | Write-one force strobe for flags |
| nmiint_clr_i | input | 1 | Clear strobe for the interrupt-status bit |
| wd_period_we_i | input | 1 | Period write strobe |
| wd_period_i | input | 16 | New watchdog period |
| flag_o | output | 4 | Latched fault flags |
| nmiint_o | output | 1 | Interrupt-status bit |
| nmi_req_o | output | 1 | Single-cycle NMI request to the CPU |
| trip_o | output | 1 | PWM protection trip |
| wd_count_o | output | 16 | Watchdog counter value |
| wd_period_o | output | 16 | Programmed watchdog period |
| wd_reset_o | output | 1 | Single-cycle system-reset pulse |

## Verification
The assertions check these rules on every cycle:
- An active fault level always shows as a set flag on the next edge.
- No flag and no trip falls unless a clear of that bit was strobed.
- Both the request and the reset are single-cycle pulses.
- The counter is back at zero one edge after the flags are gone.

Some behaviour only the bench's scenarios can show:
- A clear refused while the clock-failure level persists.
- A clear and a force of the same bit in the same cycle.
- A new request after the interrupt-status bit is cleared while flags remain.
- A reset pulse that lands exactly one edge after the counter reaches the period.
- Period rewrites below the running count.

// File: rtl/fault_nmi_pkg.sv
package fault_nmi_pkg;
  localparam int unsigned SRC_CLKFAIL = 0;
  localparam int unsigned SRC_RAMECC  = 1;
  localparam int unsigned SRC_FLSECC  = 2;
  localparam int unsigned SRC_SPARE   = 3;
  localparam int unsigned NUM_SRC_DEF = 4;
  localparam int unsigned WD_W_DEF    = 16;
endpackage

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fault_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               clr_we_i,
  input  logic               force_we_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic set_k;
    logic clr_k;

    always_comb begin
      set_k     = fault_i[k] | (force_we_i & mask_i[k]);
      clr_k     = clr_we_i & mask_i[k];
      flag_d[k] = set_k | (flag_q[k] & ~clr_k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else begin
        flag_q[k] <= flag_d[k];
      end
    end

    // R2
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i[k] |=> flag_q[k]);

    // R4
    fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[k]) |-> $past(clr_we_i && mask_i[k]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/nmi_pulse_gen.sv
module nmi_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_flag_i,
  input  logic nmiint_clr_i,
  output logic nmi_req_o,
  output logic nmiint_o
);
  logic req_q, req_d;
  logic nmiint_q, nmiint_d;

  always_comb begin
    req_d = any_flag_i & ~nmiint_q;
    if (nmiint_q) begin
      nmiint_d = ~nmiint_clr_i;
    end else begin
      nmiint_d = any_flag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      nmiint_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      nmiint_q <= nmiint_d;
    end
  end

  // R6
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R6
  req_marks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> nmiint_q);

  // R7
  req_needs_clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!nmiint_q));

  assign nmi_req_o = req_q;
  assign nmiint_o  = nmiint_q;
endmodule

// File: rtl/nmi_wdog.sv
module nmi_wdog #(
  parameter int unsigned         WD_W       = 16,
  parameter logic [WD_W-1:0]     PERIOD_RST = 16'd512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_flag_i,
  input  logic            period_we_i,
  input  logic [WD_W-1:0] period_i,
  output logic [WD_W-1:0] count_o,
  output logic [WD_W-1:0] period_o,
  output logic            reset_o
);
  localparam logic [WD_W-1:0] ONE = WD_W'(1);

  logic [WD_W-1:0] cnt_q, cnt_d;
  logic [WD_W-1:0] per_q, per_d;
  logic            exp_q, exp_d;
  logic            rst_q, rst_d;
  logic            at_limit;

  always_comb begin
    at_limit = (cnt_q >= per_q);
    per_d    = period_we_i ? period_i : per_q;
    rst_d    = any_flag_i & at_limit & ~exp_q;
    if (!any_flag_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else begin
      cnt_d = at_limit ? cnt_q : (cnt_q + ONE);
      exp_d = exp_q | rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= PERIOD_RST;
      exp_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      exp_q <= exp_d;
      rst_q <= rst_d;
    end
  end

  // R8
  idle_counter_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_flag_i |=> (cnt_q == '0));

  // R9
  reset_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);

  // R9
  reset_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(cnt_q >= per_q));

  assign count_o  = cnt_q;
  assign period_o = per_q;
  assign reset_o  = rst_q;
endmodule

// File: rtl/fault_nmi_ctrl.sv
module fault_nmi_ctrl
  import fault_nmi_pkg::*;
#(
  parameter int unsigned     NUM_SRC    = NUM_SRC_DEF,
  parameter int unsigned     WD_W       = WD_W_DEF,
  parameter logic [WD_W-1:0] PERIOD_RST = 16'd512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fault_i,
  input  logic [NUM_SRC-1:0] reg_mask_i,
  input  logic               flag_clr_i,
  input  logic               flag_force_i,
  input  logic               nmiint_clr_i,
  input  logic               wd_period_we_i,
  input  logic [WD_W-1:0]    wd_period_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               nmiint_o,
  output logic               nmi_req_o,
  output logic               trip_o,
  output logic [WD_W-1:0]    wd_count_o,
  output logic [WD_W-1:0]    wd_period_o,
  output logic               wd_reset_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] flags;
  logic               any_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  fault_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fault_i    (fault_i),
    .mask_i     (reg_mask_i),
    .clr_we_i   (flag_clr_i),
    .force_we_i (flag_force_i),
    .flag_o     (flags)
  );

  assign any_flag = |flags;

  nmi_pulse_gen u_pulse (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .any_flag_i   (any_flag),
    .nmiint_clr_i (nmiint_clr_i),
    .nmi_req_o    (nmi_req_o),
    .nmiint_o     (nmiint_o)
  );

  nmi_wdog #(.WD_W(WD_W), .PERIOD_RST(PERIOD_RST)) u_wdog (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .any_flag_i  (any_flag),
    .period_we_i (wd_period_we_i),
    .period_i    (wd_period_i),
    .count_o     (wd_count_o),
    .period_o    (wd_period_o),
    .reset_o     (wd_reset_o)
  );

  assign flag_o = flags;
  assign trip_o = flags[SRC_CLKFAIL];

  // R3
  trip_release_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(trip_o) |-> $past(flag_clr_i && reg_mask_i[SRC_CLKFAIL]));

  // R3
  trip_on_clock_fail_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault_i[SRC_CLKFAIL] |=> trip_o);
endmodule

// File: tb/fault_nmi_ctrl_bench.sv
module fault_nmi_ctrl_bench;
  localparam int N = 4;
  localparam int W = 16;
  localparam logic [W-1:0] PDEF = 16'd512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] fault_i, reg_mask_i;
  logic         flag_clr_i, flag_force_i, nmiint_clr_i, wd_period_we_i;
  logic [W-1:0] wd_period_i;
  logic [N-1:0] flag_o;
  logic         nmiint_o, nmi_req_o, trip_o, wd_reset_o;
  logic [W-1:0] wd_count_o, wd_period_o;

  fault_nmi_ctrl u_fault_nmi_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .reg_mask_i(reg_mask_i),
    .flag_clr_i(flag_clr_i), .flag_force_i(flag_force_i),
    .nmiint_clr_i(nmiint_clr_i), .wd_period_we_i(wd_period_we_i),
    .wd_period_i(wd_period_i), .flag_o(flag_o), .nmiint_o(nmiint_o),
    .nmi_req_o(nmi_req_o), .trip_o(trip_o), .wd_count_o(wd_count_o),
    .wd_period_o(wd_period_o), .wd_reset_o(wd_reset_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  model_run = 1'b0;

  logic [N-1:0] m_flag;
  logic         m_nmiint, m_req, m_exp, m_wdrst;
  logic [W-1:0] m_cnt, m_per;

  function automatic logic [N-1:0] exp_flags(input logic [N-1:0] cur,
      input logic [N-1:0] flt, input logic [N-1:0] msk, input logic clr, input logic frc);
    logic [N-1:0] setm;
    setm = flt | (frc ? msk : '0);
    return setm | (cur & ~(clr ? msk : '0));
  endfunction

  function automatic logic exp_status(input logic cur, input logic any, input logic clr);
    return cur ? ~clr : any;
  endfunction

  always @(posedge clk) begin
    logic any, fire, lim;
    if (!model_run) begin
      m_flag = '0; m_nmiint = 0; m_req = 0; m_exp = 0; m_wdrst = 0;
      m_cnt = '0; m_per = PDEF;
    end else begin
      any  = |m_flag;
      lim  = (m_cnt >= m_per);
      fire = any & lim & ~m_exp;
      m_req    = any & ~m_nmiint;
      m_nmiint = exp_status(m_nmiint, any, nmiint_clr_i);
      m_wdrst  = fire;
      m_exp    = any ? (m_exp | fire) : 1'b0;
      m_cnt    = !any ? '0 : (lim ? m_cnt : m_cnt + 16'd1);
      m_per    = wd_period_we_i ? wd_period_i : m_per;
      m_flag   = exp_flags(m_flag, fault_i, reg_mask_i, flag_clr_i, flag_force_i);
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", "flags", int'(flag_o), int'(m_flag));
    check("R3", "trip", int'(trip_o), int'(m_flag[0]));
    check("R6", "nmi request", int'(nmi_req_o), int'(m_req));
    check("R7", "nmi status", int'(nmiint_o), int'(m_nmiint));
    check("R8", "wd count", int'(wd_count_o), int'(m_cnt));
    check("R9", "wd reset", int'(wd_reset_o), int'(m_wdrst));
    check("R10", "wd period", int'(wd_period_o), int'(m_per));
  endtask

  task automatic tick();
    @(negedge clk);
    if (model_run) compare_all();
  endtask

  task automatic idle();
    fault_i = '0; reg_mask_i = '0; flag_clr_i = 0; flag_force_i = 0;
    nmiint_clr_i = 0; wd_period_we_i = 0; wd_period_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses;
    logic [31:0] r;
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_run = 1'b1;

    // R1 reset state
    check("R1", "flags at reset", int'(flag_o), 0);
    check("R1", "status at reset", int'(nmiint_o | nmi_req_o | trip_o | wd_reset_o), 0);
    check("R1", "count at reset", int'(wd_count_o), 0);
    check("R1", "period at reset", int'(wd_period_o), int'(PDEF));

    // R10 period write
    wd_period_we_i = 1; wd_period_i = 16'd6;
    tick(); idle();
    check("R10", "period after write", int'(wd_period_o), 6);

    // R2 / R3 clock failure pulse
    fault_i = 4'b0001;
    tick(); idle();
    check("R2", "clock fail flag", int'(flag_o[0]), 1);
    check("R3", "trip asserted", int'(trip_o), 1);
    tick();
    check("R6", "request pulse", int'(nmi_req_o), 1);
    check("R6", "status set", int'(nmiint_o), 1);
    tick();
    check("R6", "request single cycle", int'(nmi_req_o), 0);

    // R4 clear refused while failure persists
    fault_i = 4'b0001; flag_clr_i = 1; reg_mask_i = 4'b0001;
    tick();
    check("R4", "clear refused", int'(flag_o[0]), 1);
    check("R3", "trip held", int'(trip_o), 1);
    fault_i = '0;
    tick(); idle();
    check("R4", "clear accepted", int'(flag_o[0]), 0);
    check("R3", "trip released", int'(trip_o), 0);
    tick();
    check("R8", "count zero after clear", int'(wd_count_o), 0);

    // R5 force with clear in the same cycle
    flag_force_i = 1; flag_clr_i = 1; reg_mask_i = 4'b0100;
    tick(); idle();
    check("R5", "force wins over clear", int'(flag_o), 4);
    check("R5", "force leaves trip low", int'(trip_o), 0);

    // R7 re-arm after status clear
    nmiint_clr_i = 1;
    tick(); idle();
    check("R7", "status cleared", int'(nmiint_o), 0);
    tick();
    check("R7", "new request", int'(nmi_req_o), 1);

    // R9 watchdog expiry
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (wd_reset_o) pulses++;
    end
    check("R9", "reset pulse count", pulses, 1);
    check("R9", "counter held", int'(wd_count_o), 6);

    flag_clr_i = 1; reg_mask_i = '1;
    tick(); idle();
    check("R4", "all flags cleared", int'(flag_o), 0);
    tick();
    check("R8", "counter back to zero", int'(wd_count_o), 0);

    // random stimulus
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      fault_i        = (r[3:0] == 4'd0) ? 4'(r[7:4]) : '0;
      reg_mask_i     = 4'(r[11:8]);
      flag_clr_i     = (r[13:12] == 2'd0);
      flag_force_i   = (r[18:14] == 5'd0);
      nmiint_clr_i   = (r[21:19] == 3'd0);
      wd_period_we_i = (r[28:22] == 7'd0);
      wd_period_i    = 16'd3 + 16'(r[31:27]);
      tick();
    end
    idle();
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule